// File: doc/BRIEF.md
# Iterative Booth Multiply-Accumulate Unit

This block computes the low 32 bits of a 32 by 32 product, optionally adding a 32-bit addend. It walks the multiplier two bits at a time using radix-4 Booth digits. Each clock it adds or subtracts one shifted copy of the multiplicand through a single shared adder.

A one-cycle start strobe loads the operands while the unit is idle. The partial-sum register starts at the addend for multiply-accumulate, or at zero for a plain multiply. The run ends as soon as the multiplier bits still to be consumed, together with the bit carried between steps, are all zeros or all ones. A full-length run takes 16 steps. A one-cycle done strobe then marks the finished result.

A carry output exposes the Booth bit carried between steps. Its value after an operation is implementation-defined.

Top module: `booth_mac_unit`

## Requirements
- R1: With the accumulate enable low, the result is (A × B) mod 2^32.
- R2: With the accumulate enable high, the result is (A × B + C) mod 2^32.
- R3: Done is raised at most 16 cycles after the clock edge that accepts start.
- R4: The run ends early. The done strobe rises exactly n clock edges after the accepting edge, where n is the smallest value in 1..16 for which bits 31 down to 2n−1 of B are all equal.
- R5: Each step applies the Booth digit chosen by the trio {B[2i+1], B[2i], previous bit}. The trio values 000 and 111 give 0, 001 and 010 give +A, 011 gives +2A, 100 gives −2A, and 101 and 110 give −A. The previous bit is 0 for the first step.
- R6: Done is high for one cycle and then drops, unless a new operation completes at once. The result output holds the finished value while done is high.
- R7: A start pulse that arrives while an operation is running is ignored. It changes neither that operation's result nor its latency.
- R8: After reset, done is low and the unit is idle.
- R9: Results are correct for zero, negative and most-negative operands in any position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe, taken only when idle |
| accEnIn | input | 1 | 1 = add opCIn to the product |
| opAIn | input | 32 | Multiplicand A |
| opBIn | input | 32 | Multiplier B |
| opCIn | input | 32 | Addend C |
| resultOut | output | 32 | Low 32 bits of the result |
| doneOut | output | 1 | One-cycle completion strobe |
| carryOut | output | 1 | Booth bit carried between steps (value implementation-defined) |

## Verification
The embedded assertions check these properties on every cycle:
- the partial sum is loaded from the addend or from zero when an operation is accepted;
- the multiplier keeps its sign across arithmetic shifts;
- a run never goes past its sixteenth step;
- done is a single-cycle pulse;
- a start pulse seen while busy does not reload the unit.

Only the bench's scenarios can show arithmetic correctness and the exact early-exit latency. Those scenarios cover zero, all-ones, alternating and most-negative multipliers, signed multiply-accumulate, and a start pulse injected in the middle of a run.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } macCtl_t;

  typedef enum logic [2:0] {
    DIG_ZERO,
    DIG_POS1,
    DIG_POS2,
    DIG_NEG1,
    DIG_NEG2
  } boothDigit_t;

  function automatic boothDigit_t decodeDigit(input logic [2:0] trio);
    boothDigit_t d;
    case (trio)
      3'b001, 3'b010: d = DIG_POS1;
      3'b011:         d = DIG_POS2;
      3'b100:         d = DIG_NEG2;
      3'b101, 3'b110: d = DIG_NEG1;
      default:        d = DIG_ZERO;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth_mac_ctrl.sv
module booth_mac_ctrl
  import booth_mac_pkg::*;
#(
  parameter int STEPS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    tailUniform,
  output macCtl_t ctl,
  output logic    doneOut
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;

  ctlState_t      stateQ;
  logic [CW-1:0]  stepQ;
  logic           doneQ;

  always_comb begin
    ctl.load   = startIn && (stateQ == ST_IDLE);
    ctl.step   = (stateQ == ST_RUN);
    ctl.finish = ctl.step && ((stepQ == CW'(STEPS - 1)) || tailUniform);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stepQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= ctl.finish;
      if (ctl.load) begin
        stateQ <= ST_RUN;
        stepQ  <= '0;
      end else if (ctl.step) begin
        stepQ <= stepQ + 1'b1;
        if (ctl.finish) stateQ <= ST_IDLE;
      end
    end
  end

  assign doneOut = doneQ;

  // R3: the last permitted step always ends the run
  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && stepQ == CW'(STEPS - 1)) |=> (stateQ == ST_IDLE));

  // R6: done lasts one cycle when no new run is launched
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !startIn && stateQ == ST_IDLE) |=> !doneQ);

  // R7: start while running just advances the step counter
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && startIn && !ctl.finish) |=>
      (stateQ == ST_RUN && stepQ == $past(stepQ) + 1'b1));

endmodule

// File: rtl/booth_mac_dpath.sv
module booth_mac_dpath
  import booth_mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  macCtl_t      ctl,
  input  logic         accEnIn,
  input  logic [W-1:0] opAIn,
  input  logic [W-1:0] opBIn,
  input  logic [W-1:0] opCIn,
  output logic         tailUniform,
  output logic [W-1:0] resultOut,
  output logic         carryOut
);
  logic [W-1:0] mcandQ, mplQ, sumQ;
  logic         prevQ;
  boothDigit_t  digit;
  logic [W-1:0] addend, sumNext;
  logic         negate;

  always_comb begin
    digit  = decodeDigit({mplQ[1:0], prevQ});
    addend = '0;
    negate = 1'b0;
    case (digit)
      DIG_POS1: addend = mcandQ;
      DIG_POS2: addend = mcandQ << 1;
      DIG_NEG1: begin addend = ~mcandQ;        negate = 1'b1; end
      DIG_NEG2: begin addend = ~(mcandQ << 1); negate = 1'b1; end
      default:  addend = '0;
    endcase
    sumNext = sumQ + addend + W'(negate);
  end

  // remaining multiplier bits plus the carried bit are mplQ[W-1:1] after this step
  assign tailUniform = (&mplQ[W-1:1]) | ~(|mplQ[W-1:1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandQ <= '0;
      mplQ   <= '0;
      sumQ   <= '0;
      prevQ  <= 1'b0;
    end else if (ctl.load) begin
      mcandQ <= opAIn;
      mplQ   <= opBIn;
      prevQ  <= 1'b0;
      sumQ   <= accEnIn ? opCIn : '0;
    end else if (ctl.step) begin
      sumQ   <= sumNext;
      mcandQ <= mcandQ << 2;
      mplQ   <= {{2{mplQ[W-1]}}, mplQ[W-1:2]};
      prevQ  <= mplQ[1];
    end
  end

  assign resultOut = sumQ;
  assign carryOut  = prevQ;

  // R2: partial sum starts from addend or zero
  assert_sum_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (sumQ == ($past(accEnIn) ? $past(opCIn) : '0)));

  // R9: arithmetic shift keeps the multiplier sign
  assert_sign_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (mplQ[W-1] == $past(mplQ[W-1])));

endmodule

// File: rtl/booth_mac_unit.sv
module booth_mac_unit
  import booth_mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         accEnIn,
  input  logic [W-1:0] opAIn,
  input  logic [W-1:0] opBIn,
  input  logic [W-1:0] opCIn,
  output logic [W-1:0] resultOut,
  output logic         doneOut,
  output logic         carryOut
);
  localparam int STEPS = W / 2;

  macCtl_t ctl;
  logic    tailUniform;

  booth_mac_ctrl #(.STEPS(STEPS)) ctrl_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .tailUniform(tailUniform),
    .ctl(ctl), .doneOut(doneOut)
  );

  booth_mac_dpath #(.W(W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accEnIn(accEnIn),
    .opAIn(opAIn), .opBIn(opBIn), .opCIn(opCIn),
    .tailUniform(tailUniform), .resultOut(resultOut), .carryOut(carryOut)
  );

endmodule

// File: tb/booth_mac_unit_tb_top.sv
module booth_mac_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startIn, accEnIn;
  logic [31:0] opAIn, opBIn, opCIn;
  logic [31:0] resultOut;
  logic        doneOut, carryOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mac_unit dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .accEnIn(accEnIn),
    .opAIn(opAIn), .opBIn(opBIn), .opCIn(opCIn),
    .resultOut(resultOut), .doneOut(doneOut), .carryOut(carryOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4: smallest n with B[31:2n-1] uniform
  function automatic int expLat(input logic [31:0] b);
    for (int i = 1; i <= 16; i++) begin
      logic same = 1'b1;
      for (int k = 2*i - 1; k <= 31; k++)
        if (b[k] != b[31]) same = 1'b0;
      if (same) return i;
    end
    return 16;
  endfunction

  task automatic runOp(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic en);
    int cyc = 0;
    logic [31:0] exp = a * b + (en ? c : 32'd0);
    @(negedge clk);
    opAIn = a; opBIn = b; opCIn = c; accEnIn = en; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    opAIn = ~a; opBIn = ~b; opCIn = ~c;
    do begin
      @(negedge clk);
      cyc++;
    end while (!doneOut && cyc < 40);
    chk({req, " result"}, resultOut, exp);
    chk("R4 latency", cyc, expLat(b));
    chk("R3 bound", (cyc <= 16), 1);
    @(negedge clk);
    chk("R6 done pulse", doneOut, 1'b0);
  endtask

  task automatic busyStartTest();
    int cyc = 0;
    logic [31:0] b = 32'h1234_5678;
    @(negedge clk);
    opAIn = 32'd1000; opBIn = b; opCIn = 32'd5; accEnIn = 1'b1; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) begin @(negedge clk); cyc++; end
    opAIn = 32'hDEAD_BEEF; opBIn = 32'd3; opCIn = 32'd9; accEnIn = 1'b0; startIn = 1'b1;
    @(negedge clk); cyc++;
    startIn = 1'b0;
    while (!doneOut && cyc < 40) begin @(negedge clk); cyc++; end
    chk("R7 busy start result", resultOut, 32'd1000 * b + 32'd5);
    chk("R7 busy start latency", cyc, expLat(b));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; startIn = 1'b0; accEnIn = 1'b0;
    opAIn = '0; opBIn = '0; opCIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 reset done", doneOut, 1'b0);

    runOp("R1 small", 32'd7, 32'd6, 32'd0, 1'b0);
    runOp("R1 alt", 32'h0001_2345, 32'hAAAA_AAAA, 32'd0, 1'b0);
    runOp("R5 alt", 32'hF00D_0001, 32'h5555_5555, 32'd0, 1'b0);
    runOp("R5 full", 32'h1357_9BDF, 32'h7FFF_FFFF, 32'd0, 1'b0);
    runOp("R9 zero B", 32'hFFFF_FFF3, 32'd0, 32'd0, 1'b0);
    runOp("R9 ones B", 32'd123, 32'hFFFF_FFFF, 32'd0, 1'b0);
    runOp("R9 minint", 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 1'b0);
    runOp("R9 minint B", 32'hFFFF_FFFD, 32'h8000_0000, 32'd0, 1'b0);
    runOp("R9 zero A", 32'd0, 32'h1234_5678, 32'd0, 1'b0);
    runOp("R2 mac", 32'd300, 32'd400, 32'd77, 1'b1);
    runOp("R2 mac neg", 32'hFFFF_FF00, 32'h0000_0F0F, 32'hFFFF_FFFF, 1'b1);
    runOp("R2 mac zero", 32'd0, 32'd0, 32'hCAFE_F00D, 1'b1);
    runOp("R1 acc off", 32'd9, 32'd9, 32'h1111_1111, 1'b0);
    busyStartTest();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule